// File: doc/BRIEF.md
# Block-Granular Firmware Load DMA

This engine fills a microcontroller's local instruction or data memory from external memory, one 256-byte unit per command. Software first sets a source base address across two registers. For each unit it then writes a local destination offset and an external source offset. A write to the command register starts the copy. The engine sends one read request for the unit on a request/response port. It takes 64 returned 32-bit words and writes them in order into the chosen local RAM. The idle bit in the command register shows when the unit is finished.

Instruction-memory writes go out with a secure/non-secure flag and a tag. The tag is the virtual page number taken from the destination offset. The engine checks each command before it starts. A command with the wrong unit-size code, an invalid target, a misaligned offset, or one written while a unit is still running is dropped. Any such command sets a sticky error flag. Writing zero to the control register clears that flag before a new load.

Top module: `blk_load_dma`

## Requirements
- R1: After reset the command register reads idle (bit 0) = 1 and error (bit 1) = 0, no read request is raised and no local write occurs.
- R2: The read request address equals {base_hi[8:0], base_lo[31:0], 8'h00} + source offset, truncated to 49 bits. It holds steady with the valid raised until the request is accepted.
- R3: Each accepted command produces exactly 64 local word writes. Write k goes to word address dst_offset/4 + k and carries the k-th returned beat.
- R4: Command bits [5:4] pick the target: 0 writes instruction memory with the secure flag set, 1 writes instruction memory with the secure flag clear, 2 writes data memory. Only the selected port writes.
- R5: Every instruction-memory write carries tag = dst_offset >> 8.
- R6: The idle bit reads 0 from the cycle after an accepted command write until the last word of the unit is written.
- R7: A command written while the engine is busy starts nothing and sets the error bit.
- R8: A command whose size field (bits [2:0]) is not 6, or whose target field is 3, starts nothing and sets the error bit.
- R9: A command issued while either offset has nonzero bits [7:0] starts nothing and sets the error bit.
- R10: Writing zero to the control register (address 0) clears the error bit. Writing a nonzero value there leaves it unchanged.

Register addresses: 0 control, 1 base_lo, 2 base_hi, 3 destination offset, 4 source offset, 5 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| req_valid_o | output | 1 | Unit read request valid |
| req_ready_i | input | 1 | Request accepted |
| req_addr_o | output | EXT_AW | Byte address of the unit |
| rsp_valid_i | input | 1 | Response beat valid |
| rsp_data_i | input | 32 | Response beat data |
| imem_we_o | output | 1 | Instruction memory write |
| imem_secure_o | output | 1 | Write targets the secure region |
| imem_addr_o | output | LOFS_W-2 | Instruction memory word address |
| imem_tag_o | output | LOFS_W-8 | Virtual page tag |
| imem_wdata_o | output | 32 | Instruction memory write data |
| dmem_we_o | output | 1 | Data memory write |
| dmem_addr_o | output | LOFS_W-2 | Data memory word address |
| dmem_wdata_o | output | 32 | Data memory write data |

## Verification
The bench builds the engine with its defaults: a 49-bit external address and a 16-bit local offset. At these widths a carry out of base_lo into bit 40, the all-ones high base reaching bit 48, and the last local page at offset 0xFF00 can all be tested. The responder holds off the request handshake and leaves gaps between response beats. This stresses request stability and the in-order write count across stalls.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    TGT_IMEM_SEC = 2'd0,
    TGT_IMEM_NS  = 2'd1,
    TGT_DMEM     = 2'd2,
    TGT_BAD      = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RESP} seq_st_e;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_BLO  = 3'd1;
  localparam logic [2:0] REG_BHI  = 3'd2;
  localparam logic [2:0] REG_DST  = 3'd3;
  localparam logic [2:0] REG_SRC  = 3'd4;
  localparam logic [2:0] REG_CMD  = 3'd5;

  localparam logic [2:0] SIZE_UNIT  = 3'h6;
  localparam int         UNIT_BYTES = 256;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int LOFS_W = 16,
  parameter int HI_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              busy_i,
  output logic [31:0]       reg_rdata_o,
  output logic [31:0]       base_lo_o,
  output logic [HI_W-1:0]   base_hi_o,
  output logic [LOFS_W-1:0] dst_ofs_o,
  output logic [31:0]       src_ofs_o,
  output tgt_e              tgt_o,
  output logic              start_o
);
  logic [31:0]       base_lo_q, src_q;
  logic [HI_W-1:0]   base_hi_q;
  logic [LOFS_W-1:0] dst_q;
  logic              err_q;
  logic              cmd_wr, cmd_ok, clr_err;

  assign cmd_wr  = reg_we_i && (reg_addr_i == REG_CMD);
  assign tgt_o   = tgt_e'(reg_wdata_i[5:4]);
  assign cmd_ok  = (reg_wdata_i[2:0] == SIZE_UNIT) && (tgt_o != TGT_BAD)
                && (dst_q[7:0] == 8'h00) && (src_q[7:0] == 8'h00);
  assign start_o = cmd_wr && cmd_ok && !busy_i;
  assign clr_err = reg_we_i && (reg_addr_i == REG_CTRL) && (reg_wdata_i == 32'h0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          REG_BLO: base_lo_q <= reg_wdata_i;
          REG_BHI: base_hi_q <= reg_wdata_i[HI_W-1:0];
          REG_DST: dst_q     <= reg_wdata_i[LOFS_W-1:0];
          REG_SRC: src_q     <= reg_wdata_i;
          default: ;
        endcase
      end
      if (cmd_wr && (busy_i || !cmd_ok)) err_q <= 1'b1;
      else if (clr_err)                  err_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      REG_BLO: reg_rdata_o = base_lo_q;
      REG_BHI: reg_rdata_o = 32'(base_hi_q);
      REG_DST: reg_rdata_o = 32'(dst_q);
      REG_SRC: reg_rdata_o = src_q;
      REG_CMD: reg_rdata_o = {30'h0, err_q, !busy_i};
      default: reg_rdata_o = 32'h0;
    endcase
  end

  assign base_lo_o = base_lo_q;
  assign base_hi_o = base_hi_q;
  assign dst_ofs_o = dst_q;
  assign src_ofs_o = src_q;

  assert_busy_cmd_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_i) |=> err_q);
  assert_bad_size_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[2:0] != SIZE_UNIT) |=> (err_q && !$rose(busy_i)));
  assert_clear_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err |=> !err_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int EXT_AW = 49,
  parameter int WAW    = 14,
  parameter int BEATS  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  tgt_e              tgt_i,
  input  logic [EXT_AW-1:0] ext_addr_i,
  input  logic [WAW-1:0]    word_base_i,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [EXT_AW-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  output logic              beat_we_o,
  output logic [WAW-1:0]    beat_waddr_o,
  output tgt_e              tgt_o
);
  localparam int BW = $clog2(BEATS);

  seq_st_e           st_q;
  logic [EXT_AW-1:0] addr_q;
  logic [WAW-1:0]    wbase_q;
  logic [BW-1:0]     beat_q;
  tgt_e              tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      wbase_q <= '0;
      beat_q  <= '0;
      tgt_q   <= TGT_IMEM_SEC;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          addr_q  <= ext_addr_i;
          wbase_q <= word_base_i;
          tgt_q   <= tgt_i;
          beat_q  <= '0;
          st_q    <= S_REQ;
        end
        S_REQ: if (req_ready_i) st_q <= S_RESP;
        S_RESP: if (rsp_valid_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == BW'(BEATS - 1)) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign req_valid_o  = (st_q == S_REQ);
  assign req_addr_o   = addr_q;
  assign beat_we_o    = (st_q == S_RESP) && rsp_valid_i;
  assign beat_waddr_o = wbase_q + WAW'(beat_q);
  assign tgt_o        = tgt_q;

  assert_start_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));
  assert_req_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o[7:0] == 8'h00));
endmodule

// File: rtl/dma_wr_route.sv
module dma_wr_route
  import dma_pkg::*;
#(
  parameter int WAW   = 14,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_we_i,
  input  logic [WAW-1:0]   beat_waddr_i,
  input  logic [31:0]      beat_data_i,
  input  tgt_e             tgt_i,
  output logic             imem_we_o,
  output logic             imem_secure_o,
  output logic [WAW-1:0]   imem_addr_o,
  output logic [TAG_W-1:0] imem_tag_o,
  output logic [31:0]      imem_wdata_o,
  output logic             dmem_we_o,
  output logic [WAW-1:0]   dmem_addr_o,
  output logic [31:0]      dmem_wdata_o
);
  logic           iwe_q, dwe_q, sec_q;
  logic [WAW-1:0] addr_q;
  logic [31:0]    data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iwe_q  <= 1'b0;
      dwe_q  <= 1'b0;
      sec_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      iwe_q <= beat_we_i && (tgt_i == TGT_IMEM_SEC || tgt_i == TGT_IMEM_NS);
      dwe_q <= beat_we_i && (tgt_i == TGT_DMEM);
      if (beat_we_i) begin
        sec_q  <= (tgt_i == TGT_IMEM_SEC);
        addr_q <= beat_waddr_i;
        data_q <= beat_data_i;
      end
    end
  end

  assign imem_we_o     = iwe_q;
  assign imem_secure_o = sec_q;
  assign imem_addr_o   = addr_q;
  assign imem_tag_o    = addr_q[WAW-1:WAW-TAG_W];  // page of a word-aligned unit
  assign imem_wdata_o  = data_q;
  assign dmem_we_o     = dwe_q;
  assign dmem_addr_o   = addr_q;
  assign dmem_wdata_o  = data_q;

  assert_beat_written_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_we_i |=> (imem_we_o || dmem_we_o));
  assert_one_port_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({imem_we_o, dmem_we_o}));
endmodule

// File: rtl/blk_load_dma.sv
module blk_load_dma
  import dma_pkg::*;
#(
  parameter int LOFS_W = 16,
  parameter int EXT_AW = 49,
  localparam int HI_W  = EXT_AW - 40,
  localparam int WAW   = LOFS_W - 2,
  localparam int TAG_W = LOFS_W - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [EXT_AW-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_data_i,
  output logic              imem_we_o,
  output logic              imem_secure_o,
  output logic [WAW-1:0]    imem_addr_o,
  output logic [TAG_W-1:0]  imem_tag_o,
  output logic [31:0]       imem_wdata_o,
  output logic              dmem_we_o,
  output logic [WAW-1:0]    dmem_addr_o,
  output logic [31:0]       dmem_wdata_o
);
  localparam int BEATS = UNIT_BYTES / 4;

  logic [31:0]       base_lo, src_ofs;
  logic [HI_W-1:0]   base_hi;
  logic [LOFS_W-1:0] dst_ofs;
  logic [EXT_AW-1:0] ext_addr;
  logic [WAW-1:0]    beat_waddr;
  logic              busy, start, beat_we;
  tgt_e              cmd_tgt, run_tgt;

  dma_regs #(.LOFS_W(LOFS_W), .HI_W(HI_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .busy_i(busy), .reg_rdata_o,
    .base_lo_o(base_lo), .base_hi_o(base_hi), .dst_ofs_o(dst_ofs),
    .src_ofs_o(src_ofs), .tgt_o(cmd_tgt), .start_o(start)
  );

  assign ext_addr = {base_hi, base_lo, 8'h00} + EXT_AW'(src_ofs);

  dma_seq #(.EXT_AW(EXT_AW), .WAW(WAW), .BEATS(BEATS)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .tgt_i(cmd_tgt),
    .ext_addr_i(ext_addr), .word_base_i(dst_ofs[LOFS_W-1:2]),
    .busy_o(busy), .req_valid_o, .req_ready_i, .req_addr_o,
    .rsp_valid_i, .beat_we_o(beat_we), .beat_waddr_o(beat_waddr), .tgt_o(run_tgt)
  );

  dma_wr_route #(.WAW(WAW), .TAG_W(TAG_W)) u_route (
    .clk_i, .rst_ni, .beat_we_i(beat_we), .beat_waddr_i(beat_waddr),
    .beat_data_i(rsp_data_i), .tgt_i(run_tgt),
    .imem_we_o, .imem_secure_o, .imem_addr_o, .imem_tag_o, .imem_wdata_o,
    .dmem_we_o, .dmem_addr_o, .dmem_wdata_o
  );

  assert_idle_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy)) |-> !(imem_we_o || dmem_we_o));
endmodule

// File: tb/blk_load_dma_test.sv
module blk_load_dma_test;
  import dma_pkg::*;

  typedef struct packed {
    logic [31:0] lo;
    logic [8:0]  hi;
    logic [31:0] src;
    logic [15:0] dst;
    logic [1:0]  tgt;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 9'h000, 32'h0000_0000, 16'h0000, 2'd0},
    '{32'hFFFF_FFFF, 9'h000, 32'h0000_0100, 16'h0400, 2'd1},
    '{32'h1234_5600, 9'h1FF, 32'h0000_2000, 16'hFF00, 2'd2},
    '{32'h0000_0001, 9'h0AB, 32'hFFFF_FF00, 16'h8000, 2'd0}
  };

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid, req_ready = 0;
  logic [48:0] req_addr;
  logic        rsp_valid = 0;
  logic [31:0] rsp_data = 0;
  logic        imem_we, imem_sec, dmem_we;
  logic [13:0] imem_addr, dmem_addr;
  logic [7:0]  imem_tag;
  logic [31:0] imem_wdata, dmem_wdata;

  int checks = 0, errors = 0;
  int wr_total = 0, bad_total = 0, req_total = 0;
  int wr_base = 0;
  logic [48:0] last_req = '0, exp_addr = '0;
  logic [1:0]  exp_tgt = 0;
  logic [15:0] exp_dst = 0;

  always #5 clk = ~clk;

  blk_load_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .imem_we_o(imem_we), .imem_secure_o(imem_sec), .imem_addr_o(imem_addr),
    .imem_tag_o(imem_tag), .imem_wdata_o(imem_wdata),
    .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata)
  );

  function automatic logic [31:0] mkdata(logic [48:0] a, int b);
    return a[39:8] ^ (32'(b) * 32'h9E37_79B9);
  endfunction

  // responder: delayed grant, gapped beats
  initial begin
    forever begin
      do @(negedge clk); while (!req_valid);
      repeat (2) @(negedge clk);
      req_ready = 1;
      last_req  = req_addr;
      req_total++;
      @(negedge clk);
      req_ready = 0;
      for (int b = 0; b < 64; b++) begin
        if (b % 7 == 3) begin rsp_valid = 0; @(negedge clk); end
        rsp_valid = 1;
        rsp_data  = mkdata(last_req, b);
        @(negedge clk);
      end
      rsp_valid = 0;
    end
  end

  // write monitor
  always @(negedge clk) begin
    if (imem_we || dmem_we) begin
      automatic int k = wr_total - wr_base;
      automatic logic ok;
      if (exp_tgt == 2'd2)
        ok = dmem_we && !imem_we && dmem_addr == 14'(exp_dst[15:2] + 14'(k))
             && dmem_wdata == mkdata(exp_addr, k);
      else
        ok = imem_we && !dmem_we && imem_addr == 14'(exp_dst[15:2] + 14'(k))
             && imem_wdata == mkdata(exp_addr, k) && imem_tag == exp_dst[15:8]
             && imem_sec == (exp_tgt == 2'd0);
      if (!ok) bad_total++;
      wr_total++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); rd(REG_CMD, s);
      if (s[0]) return;
    end
  endtask

  function automatic logic [31:0] cmd(logic [1:0] t, logic [2:0] sz);
    return 32'({t, 1'b0, sz});
  endfunction

  initial begin
    logic [31:0] s;
    int w0, b0, r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(REG_CMD, s);
    chk(s[1:0] == 2'b01, "R1 status", s, 1);
    chk(!req_valid && !imem_we && !dmem_we, "R1 outputs", {req_valid, imem_we, dmem_we}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      wr(REG_BLO, v.lo); wr(REG_BHI, 32'(v.hi));
      wr(REG_DST, 32'(v.dst)); wr(REG_SRC, v.src);
      exp_addr = {v.hi, v.lo, 8'h00} + 49'(v.src);
      exp_tgt = v.tgt; exp_dst = v.dst;
      wr_base = wr_total; w0 = wr_total; b0 = bad_total; r0 = req_total;
      wr(REG_CMD, cmd(v.tgt, 3'h6));
      rd(REG_CMD, s);
      chk(s[0] == 1'b0, "R6 busy after command", s, 0);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(req_total - r0 == 1 && last_req == exp_addr, "R2 request address", last_req, exp_addr);
      chk(wr_total - w0 == 64, "R3 write count", wr_total - w0, 64);
      chk(bad_total == b0, "R3/R4/R5 write content", bad_total - b0, 0);
      rd(REG_CMD, s);
      chk(s[1:0] == 2'b01, "R6 idle after unit", s, 1);
    end

    // R7: command while busy
    wr(REG_BLO, 32'h0000_0010); wr(REG_BHI, 0); wr(REG_DST, 32'h0100); wr(REG_SRC, 0);
    exp_addr = 49'h1000; exp_tgt = 2'd2; exp_dst = 16'h0100;
    wr_base = wr_total; w0 = wr_total; b0 = bad_total; r0 = req_total;
    wr(REG_CMD, cmd(2'd2, 3'h6));
    wr(REG_CMD, cmd(2'd0, 3'h6));
    rd(REG_CMD, s);
    chk(s[1] == 1'b1, "R7 error on busy command", s, 2);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(req_total - r0 == 1 && wr_total - w0 == 64 && bad_total == b0,
        "R7 busy command ignored", wr_total - w0, 64);

    // R10: nonzero control write keeps, zero clears
    wr(REG_CTRL, 32'h1);
    rd(REG_CMD, s);
    chk(s[1] == 1'b1, "R10 nonzero keeps error", s[1], 1);
    wr(REG_CTRL, 32'h0);
    rd(REG_CMD, s);
    chk(s[1] == 1'b0, "R10 zero clears error", s[1], 0);

    // R8: bad size, bad target
    r0 = req_total; w0 = wr_total;
    wr(REG_CMD, cmd(2'd0, 3'h5));
    rd(REG_CMD, s);
    chk(s[1:0] == 2'b11, "R8 size code rejected", s, 3);
    wr(REG_CTRL, 0);
    wr(REG_CMD, cmd(2'd3, 3'h6));
    rd(REG_CMD, s);
    chk(s[1:0] == 2'b11, "R8 target 3 rejected", s, 3);
    wr(REG_CTRL, 0);

    // R9: misaligned offsets
    wr(REG_DST, 32'h0404);
    wr(REG_CMD, cmd(2'd1, 3'h6));
    rd(REG_CMD, s);
    chk(s[1:0] == 2'b11, "R9 dst misaligned rejected", s, 3);
    wr(REG_CTRL, 0); wr(REG_DST, 32'h0400); wr(REG_SRC, 32'h0000_0180);
    wr(REG_CMD, cmd(2'd1, 3'h6));
    rd(REG_CMD, s);
    chk(s[1:0] == 2'b11, "R9 src misaligned rejected", s, 3);
    repeat (10) @(negedge clk);
    chk(req_total == r0 && wr_total == w0, "R8/R9 nothing started", req_total - r0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule